// File: doc/BRIEF.md
# Configuration Readback Serial Controller

This block sends stored configuration frames out through a single serial output when a request pin asks for them. The request pin and the serial output are both timed by the configuration clock. A falling edge on the request pin starts a readback. After a fixed lead-in, the controller fetches one frame word at a time from a synchronous frame memory that has a one-cycle read latency. It shifts each word out MSB first, with a low start bit in front and a high stop bit behind. No preamble or length field is sent, and data bits are not inverted. Raising the request aborts the transfer. A restart from frame 0 needs the request held high for at least two clock edges before it falls again.

A two-bit permission setting limits how many readbacks are served. A two-bit capture mode decides when the capture write enable is raised for the internal-state capture RAMs. The request pin is shared with the global three-state function. Before configuration completes, and whenever the role select picks the three-state role, the pin drives the three-state output directly. When the pin acts as the readback request, the three-state output comes from an alternate input.

Top module: `cfgrb_readback_ctrl`

## Requirements
- R1: After reset, and whenever no readback is active, `rd_bit` is 1, `mem_re` is 0 and the capture entry pulse is clear.
- R2: A readback starts only on a rising clock edge that samples the request low after it was sampled high. The first start bit appears on `rd_bit` exactly `LEAD_LAT` edges after that edge (default 3).
- R3: Each frame is sent as one 0 start bit, then `FRAME_W` data bits MSB first and not inverted, then one 1 stop bit. Frames go out in order 0 to `FRAMES-1`, one bit per rising edge, with no preamble.
- R4: An edge that samples the request high ends any active readback, and `rd_bit` is 1 after that edge.
- R5: A new readback starting at frame 0 needs at least two consecutive edges that sample the request high before it falls. After a shorter high pulse the block stays idle.
- R6: Permission 2'b00 prohibits readback: `mem_re` stays 0 and `rd_bit` stays 1.
- R7: Permission 2'b01 serves only the first readback that reaches its first start bit; later requests are ignored until reset. Permission 2'b10 or 2'b11 serves any number of readbacks.
- R8: After the stop bit of the last frame, `rd_bit` stays 1 until a new qualifying falling edge.
- R9: Capture mode bit 0 raises `cap_we` for the one cycle that follows an accepted readback start. Bit 1 raises it while `cap_sig` is low. Mode 2'b11 is the OR of both, and mode 2'b00 never raises it.
- R10: With mode bit 1 set and `cap_sig` held at 0, `cap_we` stays 1 continuously.
- R11: While `cfg_done` is 0, readback is disabled and `ts_all` equals `cfg_rd_req`.
- R12: After configuration, `role_sel`=0 makes `ts_all` follow `cfg_rd_req` and disables readback. `role_sel`=1 makes the pin the readback request and takes `ts_all` from `ts_alt`.
- R13: `mem_re` is 1 during the cycle before each start-bit edge, with `mem_addr` equal to that frame's index. The word is used at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_req | input | 1 | Shared pin: readback request (active low) or three-state control |
| cfg_done | input | 1 | Configuration complete |
| role_sel | input | 1 | 1: pin is readback request; 0: pin drives three-state |
| ts_alt | input | 1 | Alternate three-state source when the pin is the request |
| perm | input | 2 | 00 prohibit, 01 once, 10/11 unrestricted |
| cap_mode | input | 2 | bit0 capture on entry, bit1 capture on low `cap_sig` |
| cap_sig | input | 1 | Internal capture signal, active low |
| mem_rdata | input | FRAME_W | Frame word, valid one cycle after `mem_re` |
| mem_re | output | 1 | Frame memory read enable |
| mem_addr | output | max(1,clog2(FRAMES)) | Frame index to read |
| rd_bit | output | 1 | Serial readback data, idles high |
| ts_all | output | 1 | Global three-state control |
| cap_we | output | 1 | Capture RAM write enable |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `perm`, `cap_mode` and `role_sel` change only while no readback is in progress. Under that assumption, a prohibited setting can never meet a frame fetch that is already under way. The stimulus changes every input shortly after a rising edge and reprograms the policy inputs only in idle gaps, after a transfer has finished or been aborted. It still drives request pulses of one, two and three edges, aborts in mid-frame, and holds the capture signal low for long stretches.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4
    } rb_state_e;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_ONCE = 2'b01;

endpackage

// File: rtl/cfgrb_req_watch.sv
module cfgrb_req_watch #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic fall_ok
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] hi_cnt;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.prev = req;
        if (!req)
            w_d.hi_cnt = '0;
        else if (w_q.hi_cnt < CW'(HOLD))
            w_d.hi_cnt = w_q.hi_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign fall_ok = w_q.prev & ~req & (w_q.hi_cnt >= CW'(HOLD));

endmodule

// File: rtl/cfgrb_capture.sv
module cfgrb_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cap_sig,
    input  logic       entry,
    output logic       cap_we
);
    logic entry_d, entry_q;

    always_comb entry_d = entry;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) entry_q <= 1'b0;
        else        entry_q <= entry_d;
    end

    assign cap_we = (mode[0] & entry_q) | (mode[1] & ~cap_sig);

endmodule

// File: rtl/cfgrb_serializer.sv
module cfgrb_serializer
    import cfgrb_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int FRAMES   = 8,
    parameter int LEAD_LAT = 3,
    localparam int FW      = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               halt,
    input  logic [FRAME_W-1:0] mem_rdata,
    output logic               mem_re,
    output logic [FW-1:0]      mem_addr,
    output logic               rd_bit,
    output logic               first_start
);
    localparam int LCW       = $clog2(LEAD_LAT + 1);
    localparam int BW        = $clog2(FRAME_W);
    localparam int LEAD_INIT = (LEAD_LAT > 1) ? LEAD_LAT - 2 : 0;

    typedef struct packed {
        rb_state_e          st;
        logic [LCW-1:0]     lead;
        logic [BW-1:0]      bidx;
        logic [FW-1:0]      frame;
        logic [FRAME_W-1:0] sh;
        logic               first;
        logic               rd;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (halt) begin
            s_d.st = ST_IDLE;
            s_d.rd = 1'b1;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    s_d.rd = 1'b1;
                    if (launch) begin
                        s_d.frame = '0;
                        s_d.lead  = LCW'(LEAD_INIT);
                        s_d.st    = (LEAD_LAT > 1) ? ST_LEAD : ST_START;
                    end
                end
                ST_LEAD: begin
                    s_d.rd = 1'b1;
                    if (s_q.lead == '0) s_d.st = ST_START;
                    else                s_d.lead = s_q.lead - 1'b1;
                end
                ST_START: begin
                    s_d.rd    = 1'b0;
                    s_d.st    = ST_DATA;
                    s_d.bidx  = BW'(FRAME_W - 1);
                    s_d.first = 1'b1;
                end
                ST_DATA: begin
                    if (s_q.first) begin
                        s_d.rd    = mem_rdata[FRAME_W-1];
                        s_d.sh    = mem_rdata << 1;
                        s_d.first = 1'b0;
                    end else begin
                        s_d.rd = s_q.sh[FRAME_W-1];
                        s_d.sh = s_q.sh << 1;
                    end
                    if (s_q.bidx == '0) s_d.st = ST_STOP;
                    else                s_d.bidx = s_q.bidx - 1'b1;
                end
                ST_STOP: begin
                    s_d.rd = 1'b1;
                    if (s_q.frame == FW'(FRAMES - 1)) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.frame = s_q.frame + 1'b1;
                        s_d.st    = ST_START;
                    end
                end
                default: begin
                    s_d.st = ST_IDLE;
                    s_d.rd = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.rd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_bit      = s_q.rd;
    assign mem_re      = (s_q.st == ST_START);
    assign mem_addr    = s_q.frame;
    assign first_start = (s_q.st == ST_START) && (s_q.frame == '0) && !halt;

endmodule

// File: rtl/cfgrb_readback_ctrl.sv
module cfgrb_readback_ctrl
    import cfgrb_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int FRAMES   = 8,
    parameter int LEAD_LAT = 3,
    parameter int HOLD     = 2,
    localparam int FW      = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_rd_req,
    input  logic               cfg_done,
    input  logic               role_sel,
    input  logic               ts_alt,
    input  logic [1:0]         perm,
    input  logic [1:0]         cap_mode,
    input  logic               cap_sig,
    input  logic [FRAME_W-1:0] mem_rdata,
    output logic               mem_re,
    output logic [FW-1:0]      mem_addr,
    output logic               rd_bit,
    output logic               ts_all,
    output logic               cap_we
);
    logic enable, fall_ok, permitted, launch, halt, first_start;
    logic used_d, used_q;

    assign enable = cfg_done & role_sel;
    assign halt   = ~enable | cfg_rd_req;
    assign ts_all = enable ? ts_alt : cfg_rd_req;

    always_comb begin
        unique case (perm)
            PERM_NONE: permitted = 1'b0;
            PERM_ONCE: permitted = ~used_q;
            default:   permitted = 1'b1;
        endcase
    end

    assign launch = fall_ok & enable & permitted;

    always_comb used_d = used_q | first_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= 1'b0;
        else        used_q <= used_d;
    end

    cfgrb_req_watch #(.HOLD(HOLD)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cfg_rd_req),
        .fall_ok (fall_ok)
    );

    cfgrb_serializer #(
        .FRAME_W  (FRAME_W),
        .FRAMES   (FRAMES),
        .LEAD_LAT (LEAD_LAT)
    ) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .halt        (halt),
        .mem_rdata   (mem_rdata),
        .mem_re      (mem_re),
        .mem_addr    (mem_addr),
        .rd_bit      (rd_bit),
        .first_start (first_start)
    );

    cfgrb_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cap_mode),
        .cap_sig (cap_sig),
        .entry   (launch),
        .cap_we  (cap_we)
    );

endmodule

// File: rtl/cfgrb_readback_ctrl_chk.sv
module cfgrb_readback_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_rd_req,
    input logic       cfg_done,
    input logic       role_sel,
    input logic [1:0] perm,
    input logic [1:0] cap_mode,
    input logic       cap_sig,
    input logic       mem_re,
    input logic       rd_bit,
    input logic       cap_we,
    input logic       used
);
    // R4: a high request sample ends any transfer
    p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_req |=> rd_bit);

    // R11: nothing is sent before configuration completes
    p_unconfigured_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> rd_bit);

    // R13: a frame fetch is followed by the start bit
    p_fetch_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !cfg_rd_req && cfg_done && role_sel) |=> !rd_bit);

    // R6: prohibited permission never fetches frames
    p_prohibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (perm == 2'b00) |-> !mem_re);

    // R7: the single-use flag is sticky until reset
    p_once_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        used |=> used);

    // R10: low capture signal with bit 1 set keeps the enable on
    p_cap_cont_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode[1] && !cap_sig) |-> cap_we);

    // R9: capture mode 00 never raises the enable
    p_cap_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == 2'b00) |-> !cap_we);
endmodule

bind cfgrb_readback_ctrl cfgrb_readback_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rd_req (cfg_rd_req),
    .cfg_done   (cfg_done),
    .role_sel   (role_sel),
    .perm       (perm),
    .cap_mode   (cap_mode),
    .cap_sig    (cap_sig),
    .mem_re     (mem_re),
    .rd_bit     (rd_bit),
    .cap_we     (cap_we),
    .used       (used_q)
);

// File: tb/cfgrb_readback_ctrl_tb.sv
module cfgrb_readback_ctrl_tb;
    localparam int W   = 16;
    localparam int N   = 8;
    localparam int LAT = 3;
    localparam int FW  = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rd_req = 1'b1, cfg_done = 1'b0, role_sel = 1'b0, ts_alt = 1'b0;
    logic [1:0] perm = 2'b10, cap_mode = 2'b00;
    logic cap_sig = 1'b1;
    logic [W-1:0] mem_rdata = '0;
    logic mem_re, rd_bit, ts_all, cap_we;
    logic [FW-1:0] mem_addr;

    int errors = 0, checks = 0;
    string tag = "R1";
    logic [W-1:0] mem [N];

    always #5 clk = ~clk;

    cfgrb_readback_ctrl #(.FRAME_W(W), .FRAMES(N), .LEAD_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rd_req(cfg_rd_req), .cfg_done(cfg_done),
        .role_sel(role_sel), .ts_alt(ts_alt), .perm(perm), .cap_mode(cap_mode),
        .cap_sig(cap_sig), .mem_rdata(mem_rdata), .mem_re(mem_re),
        .mem_addr(mem_addr), .rd_bit(rd_bit), .ts_all(ts_all), .cap_we(cap_we)
    );

    always @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr];

    // behavioural reference: a queue of bits still to be sent
    int q[$];
    int m_prev = 0, m_hic = 0, m_used = 0, m_entry = 0, m_rd = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_prev = 0; m_hic = 0; m_used = 0; m_entry = 0; m_rd = 1;
        end else begin
            bit ok, acc;
            ok  = cfg_done && role_sel;
            acc = m_prev == 1 && !cfg_rd_req && m_hic >= 2 && ok && perm != 2'b00
                  && !(perm == 2'b01 && m_used == 1);
            m_hic  = cfg_rd_req ? ((m_hic < 2) ? m_hic + 1 : 2) : 0;
            m_prev = cfg_rd_req;
            m_entry = acc;
            if (!ok || cfg_rd_req) q.delete();
            if (acc) begin
                q.delete();
                for (int i = 0; i < LAT - 1; i++) q.push_back(1);
                for (int f = 0; f < N; f++) begin
                    q.push_back(100 + f);
                    for (int b = W - 1; b >= 0; b--) q.push_back(int'(mem[f][b]));
                    q.push_back(1);
                end
                m_rd = 1;
            end else if (q.size() > 0) begin
                int v;
                v = q.pop_front();
                if (v >= 100) begin
                    m_rd = 0;
                    if (v == 100) m_used = 1;
                end else m_rd = v;
            end else m_rd = 1;
        end
    end

    task automatic chk(input bit ok, input string t, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        bit ere, ecap, ets;
        ere  = q.size() > 0 && q[0] >= 100;
        ecap = (cap_mode[1] && !cap_sig) || (cap_mode[0] && m_entry == 1);
        ets  = (cfg_done && role_sel) ? ts_alt : cfg_rd_req;
        chk(rd_bit == m_rd[0], tag, "rd_bit", int'(rd_bit), m_rd);
        chk(mem_re == ere, "R13", "mem_re", int'(mem_re), int'(ere));
        if (ere) chk(mem_addr == FW'(q[0] - 100), "R13", "mem_addr",
                     int'(mem_addr), q[0] - 100);
        chk(cap_we == ecap, "R9/R10", "cap_we", int'(cap_we), int'(ecap));
        chk(ts_all == ets, "R11/R12", "ts_all", int'(ts_all), int'(ets));
    end

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // request: high for hi edges, then low for lo edges
    task automatic req_pulse(input int hi, input int lo);
        cfg_rd_req = 1'b1; go(hi);
        cfg_rd_req = 1'b0; go(lo);
    endtask

    localparam int FULL = LAT + N * (W + 2) + 4;

    initial begin
        for (int f = 0; f < N; f++) mem[f] = W'(16'hA5C3 ^ (f * 16'h1357) ^ (f << 11));
        go(3);
        tag = "R1";
        chk(rd_bit == 1'b1 && mem_re == 1'b0, "R1", "reset idle", int'(rd_bit), 1);
        rst_n = 1'b1; go(2);
        chk(rd_bit == 1'b1, "R1", "idle after reset", int'(rd_bit), 1);

        tag = "R11"; cfg_done = 1'b0; role_sel = 1'b1;
        req_pulse(3, 10); cfg_rd_req = 1'b1; go(1); cfg_rd_req = 1'b0; go(2);
        cfg_rd_req = 1'b1; go(2);

        tag = "R12"; cfg_done = 1'b1; role_sel = 1'b0;
        req_pulse(3, 10); cfg_rd_req = 1'b1; go(3);

        tag = "R2 R3 R8"; role_sel = 1'b1; ts_alt = 1'b1;
        req_pulse(3, FULL); ts_alt = 1'b0; go(20);

        tag = "R4 R5"; req_pulse(3, 40);
        req_pulse(1, 30);
        tag = "R5 R3"; req_pulse(3, FULL);
        req_pulse(2, 50); cfg_rd_req = 1'b1; go(3);

        tag = "R6"; perm = 2'b00; req_pulse(3, 40); cfg_rd_req = 1'b1; go(3);

        tag = "R7"; rst_n = 1'b0; go(2); rst_n = 1'b1; perm = 2'b01; go(2);
        req_pulse(3, 10); req_pulse(3, 10);
        req_pulse(3, FULL); req_pulse(3, 40);
        cfg_rd_req = 1'b1; go(3); perm = 2'b11;
        req_pulse(3, 60); cfg_rd_req = 1'b1; go(3);

        tag = "R9"; perm = 2'b10;
        for (int m = 0; m < 4; m++) begin
            cap_mode = 2'(m);
            req_pulse(3, 4); cap_sig = 1'b0; go(2); cap_sig = 1'b1; go(3);
            cfg_rd_req = 1'b1; go(3);
        end
        tag = "R10"; cap_mode = 2'b10; cap_sig = 1'b0; go(50);
        req_pulse(3, 30); cap_sig = 1'b1; cfg_rd_req = 1'b1; go(5);
        chk(cap_we == 1'b0, "R10", "cap_we released", int'(cap_we), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog act=0 exp=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule